// File: doc/BRIEF.md
# Phase-Frequency Detector with Dual-Loop Lock Indicator

This block compares a reference pulse train against divided feedback pulse trains, sampling every input on one fast clock. For the main loop it produces UP and DOWN enables for an external charge pump. An identical detector runs for an auxiliary loop that shares the same reference. Each detection cycle holds both enables on together for a fixed backlash interval. This removes the dead zone around zero phase error, because a tiny correction still produces a pulse on both pumps.

Each loop measures its phase error as the number of sampling cycles in which only one of its two enables is high. A loop is judged in lock when that error stays below a window that stands for one reference-input period. The two loop judgements are merged into one lock flag, and a loop that is powered down drops out of the merge. The flag reaches a pad driver as a value and an output enable, and can be configured as push-pull or open-drain. There is no data stream here, so every pin is a plain level signal with no valid/ready handshake.

Top module: `phase_lock_detect`

## Requirements
- R1: A rising edge on `ref_in` (low in one sample, high in the next) sets the UP enable of each active loop at the clock edge that samples it high. A rising edge on that loop's feedback input sets its DOWN enable in the same way.
- R2: Once UP and DOWN of a loop are both high, both stay high for exactly BACKLASH (default 2) cycles and then clear on the same edge. With zero phase error, each enable is therefore high for BACKLASH cycles.
- R3: When the feedback edge lags the reference edge by d cycles, UP is high for d+BACKLASH cycles and DOWN for BACKLASH cycles. When it leads by d cycles, the roles are swapped.
- R4: A comparison is in window when its phase error (the cycles with exactly one enable high) is below LOCK_WIN (default 4). Errors of 3 cycles are in window and errors of 4 cycles are out of window.
- R5: A loop's lock rises on the clearing edge of its LOCK_CNT-th (default 4) consecutive in-window comparison. It falls on the clearing edge of any out-of-window comparison.
- R6: While a loop's power-down flag is high, its enables are low from the next edge on, and its lock history is discarded. After release it needs LOCK_CNT new in-window comparisons to lock.
- R7: When both loops are powered up, the lock value is the AND of the two loop locks. When exactly one loop is powered down, the lock value follows the other loop alone.
- R8: When both loops are powered down, the lock value is 0.
- R9: With `lock_drive`=0 (push-pull), `lock_oe`=1 and `lock_out` equals the lock value. With `lock_drive`=1 (open-drain), `lock_out`=0 and `lock_oe` is 1 exactly when the lock value is 0.
- R10: After reset, all four enables are low and the lock value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Divided reference pulse train, shared by both loops |
| main_fb_in | input | 1 | Main loop feedback pulse train |
| aux_fb_in | input | 1 | Auxiliary loop feedback pulse train |
| main_pd | input | 1 | Main loop power-down flag |
| aux_pd | input | 1 | Auxiliary loop power-down flag |
| lock_drive | input | 1 | 0 = push-pull, 1 = open-drain lock pad |
| main_up | output | 1 | Main loop pump-up enable |
| main_dn | output | 1 | Main loop pump-down enable |
| aux_up | output | 1 | Auxiliary loop pump-up enable |
| aux_dn | output | 1 | Auxiliary loop pump-down enable |
| lock_out | output | 1 | Lock pad output value |
| lock_oe | output | 1 | Lock pad output enable |

## Verification
The feedback offset of each loop is swept from five cycles leading to five cycles lagging, with each offset repeated several times. Every sampled enable waveform is compared with the expected on-window for that offset. This separates a lag from a lead, and zero error from the dead zone. Offsets of 3 and 4 cycles sit either side of the window edge, so they expose off-by-one errors in the error count. The runs of repeated offsets show whether the lock qualifier counts exactly four comparisons, and whether one bad comparison drops lock. The same sweeps run with each loop, and then both loops, powered down, and in both pad modes. This separates the AND, the single-loop fallback and the all-off case.

// File: rtl/pfdl_pkg.sv
package pfdl_pkg;
  typedef enum logic {
    DRV_PUSH_PULL  = 1'b0,
    DRV_OPEN_DRAIN = 1'b1
  } lock_drive_e;

  localparam int unsigned NUM_LOOPS = 2;
  localparam int unsigned LOOP_MAIN = 0;
  localparam int unsigned LOOP_AUX  = 1;
endpackage

// File: rtl/pfd_core.sv
module pfd_core #(
  parameter int unsigned BACKLASH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  input  logic ref_in,
  input  logic fb_in,
  output logic up,
  output logic dn,
  output logic cmp_done
);
  localparam int unsigned BW = (BACKLASH < 2) ? 1 : $clog2(BACKLASH + 1);

  logic          ref_q, fb_q;
  logic          up_r, dn_r;
  logic [BW-1:0] bl_cnt;
  logic          ref_rise, fb_rise, both_on;

  assign ref_rise = ref_in & ~ref_q;
  assign fb_rise  = fb_in & ~fb_q;
  assign both_on  = up_r & dn_r;
  assign cmp_done = both_on && (bl_cnt == BW'(BACKLASH - 1));

  // input edge history keeps tracking through power-down
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
      fb_q  <= 1'b0;
    end else begin
      ref_q <= ref_in;
      fb_q  <= fb_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_r   <= 1'b0;
      dn_r   <= 1'b0;
      bl_cnt <= '0;
    end else if (pd) begin
      up_r   <= 1'b0;
      dn_r   <= 1'b0;
      bl_cnt <= '0;
    end else if (both_on) begin
      if (cmp_done) begin
        up_r   <= 1'b0;
        dn_r   <= 1'b0;
        bl_cnt <= '0;
      end else begin
        bl_cnt <= bl_cnt + 1'b1;
      end
    end else begin
      up_r <= up_r | ref_rise;
      dn_r <= dn_r | fb_rise;
    end
  end

  assign up = up_r;
  assign dn = dn_r;

  // checker: run length of joint-on cycles, counted apart from bl_cnt
  logic [BW:0] chk_joint;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             chk_joint <= '0;
    else if (pd)            chk_joint <= '0;
    else if (up_r && dn_r)  chk_joint <= chk_joint + 1'b1;
    else                    chk_joint <= '0;
  end

  a_r2_min_on: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(up_r) && !$past(pd)) |-> (chk_joint == (BW+1)'(BACKLASH)));

  a_r2_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(up_r) && !$past(pd)) |-> $fell(dn_r));

  a_r6_pd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!up && !dn));
endmodule

// File: rtl/lock_window.sv
module lock_window #(
  parameter int unsigned LOCK_WIN = 4,
  parameter int unsigned LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pd,
  input  logic up,
  input  logic dn,
  input  logic cmp_done,
  output logic locked
);
  localparam int unsigned EW = $clog2(LOCK_WIN + 1);
  localparam int unsigned GW = $clog2(LOCK_CNT + 1);

  logic [EW-1:0] err_cnt;
  logic [GW-1:0] good_cnt;
  logic          in_win;

  assign in_win = (err_cnt < EW'(LOCK_WIN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_cnt  <= '0;
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (pd) begin
      err_cnt  <= '0;
      good_cnt <= '0;
      locked   <= 1'b0;
    end else if (cmp_done) begin
      err_cnt <= '0;
      if (in_win) begin
        if (good_cnt != GW'(LOCK_CNT)) good_cnt <= good_cnt + 1'b1;
        locked <= (good_cnt >= GW'(LOCK_CNT - 1));
      end else begin
        good_cnt <= '0;
        locked   <= 1'b0;
      end
    end else if ((up ^ dn) && (err_cnt != EW'(LOCK_WIN))) begin
      err_cnt <= err_cnt + 1'b1;
    end
  end

  a_r5_lock_on_compare: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(cmp_done));

  a_r5_err_frozen_in_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !cmp_done && !pd) |=> locked);

  a_r6_pd_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> !locked);
endmodule

// File: rtl/phase_lock_detect.sv
module phase_lock_detect
  import pfdl_pkg::*;
#(
  parameter int unsigned BACKLASH = 2,
  parameter int unsigned LOCK_WIN = 4,
  parameter int unsigned LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  input  logic main_fb_in,
  input  logic aux_fb_in,
  input  logic main_pd,
  input  logic aux_pd,
  input  logic lock_drive,
  output logic main_up,
  output logic main_dn,
  output logic aux_up,
  output logic aux_dn,
  output logic lock_out,
  output logic lock_oe
);
  logic [NUM_LOOPS-1:0] fb_vec, pd_vec, up_vec, dn_vec, done_vec, lk_vec;
  logic                 lock_val;
  lock_drive_e          drv;

  assign fb_vec[LOOP_MAIN] = main_fb_in;
  assign fb_vec[LOOP_AUX]  = aux_fb_in;
  assign pd_vec[LOOP_MAIN] = main_pd;
  assign pd_vec[LOOP_AUX]  = aux_pd;

  for (genvar g = 0; g < NUM_LOOPS; g++) begin : g_loop
    pfd_core #(.BACKLASH(BACKLASH)) u_pfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd       (pd_vec[g]),
      .ref_in   (ref_in),
      .fb_in    (fb_vec[g]),
      .up       (up_vec[g]),
      .dn       (dn_vec[g]),
      .cmp_done (done_vec[g])
    );
    lock_window #(.LOCK_WIN(LOCK_WIN), .LOCK_CNT(LOCK_CNT)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .pd       (pd_vec[g]),
      .up       (up_vec[g]),
      .dn       (dn_vec[g]),
      .cmp_done (done_vec[g]),
      .locked   (lk_vec[g])
    );
  end

  assign main_up = up_vec[LOOP_MAIN];
  assign main_dn = dn_vec[LOOP_MAIN];
  assign aux_up  = up_vec[LOOP_AUX];
  assign aux_dn  = dn_vec[LOOP_AUX];

  // a powered-down loop votes yes, unless every loop is down
  assign lock_val = (&(lk_vec | pd_vec)) & ~(&pd_vec);

  assign drv = lock_drive_e'(lock_drive);
  always_comb begin
    if (drv == DRV_OPEN_DRAIN) begin
      lock_out = 1'b0;
      lock_oe  = ~lock_val;
    end else begin
      lock_out = lock_val;
      lock_oe  = 1'b1;
    end
  end

  a_r8_all_down_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
    (main_pd && aux_pd && !lock_drive) |-> !lock_out);

  a_r9_od_never_high: assert property (@(posedge clk) disable iff (!rst_n)
    lock_drive |-> !lock_out);

  a_r9_pp_always_driven: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_drive |-> lock_oe);

  a_r7_lock_needs_live_loop: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_drive && lock_out) |-> (|(~pd_vec)));
endmodule

// File: tb/phase_lock_detect_bench.sv
module phase_lock_detect_bench;
  localparam int BL   = 2;
  localparam int WIN  = 4;
  localparam int NQ   = 4;
  localparam int BASE = 6;
  localparam int TLEN = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0, main_fb_in = 1'b0, aux_fb_in = 1'b0;
  logic main_pd = 1'b0, aux_pd = 1'b0, lock_drive = 1'b0;
  logic main_up, main_dn, aux_up, aux_dn, lock_out, lock_oe;

  int total = 0;
  int bad   = 0;
  int gm = 0, ga = 0;

  always #10 clk = ~clk;

  phase_lock_detect #(.BACKLASH(BL), .LOCK_WIN(WIN), .LOCK_CNT(NQ)) u_phase_lock_detect (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .main_fb_in(main_fb_in),
    .aux_fb_in(aux_fb_in), .main_pd(main_pd), .aux_pd(aux_pd),
    .lock_drive(lock_drive), .main_up(main_up), .main_dn(main_dn),
    .aux_up(aux_up), .aux_dn(aux_dn), .lock_out(lock_out), .lock_oe(lock_oe)
  );

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // expected enable level in sample t (state after edge t-1)
  function automatic logic exp_on(int t, int start, int d);
    int last;
    last = ((d > 0) ? BASE + d : BASE) + BL - 1;
    return ((t - 1) >= start) && ((t - 1) <= last);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic check_lock();
    logic lm, la, lv;
    lm = (gm >= NQ);
    la = (ga >= NQ);
    if (main_pd && aux_pd)  lv = 1'b0;          // R8
    else if (main_pd)       lv = la;            // R7 aux alone
    else if (aux_pd)        lv = lm;            // R7 main alone
    else                    lv = lm & la;       // R7 AND
    if (lock_drive) begin                       // R9 open-drain
      chk("R9", "lock_out", lock_out, 0);
      chk("R7", "lock_oe(od)", lock_oe, !lv);
    end else begin                              // R9 push-pull
      chk("R9", "lock_oe", lock_oe, 1);
      chk("R5", "lock_out(pp)", lock_out, lv);
    end
  endtask

  // one comparison: feedback offsets dm, da relative to the reference edge
  task automatic compare(int dm, int da);
    for (int t = 0; t < TLEN; t++) begin
      @(negedge clk);
      if (t >= 1) begin
        int em_u, em_d, ea_u, ea_d;
        em_u = main_pd ? 0 : exp_on(t, BASE, dm);
        em_d = main_pd ? 0 : exp_on(t, BASE + dm, dm);
        ea_u = aux_pd ? 0 : exp_on(t, BASE, da);
        ea_d = aux_pd ? 0 : exp_on(t, BASE + da, da);
        // R1 R2 R3 R6: pump waveform per sample
        chk(main_pd ? "R6" : "R3", "main_up", main_up, em_u);
        chk(main_pd ? "R6" : "R2", "main_dn", main_dn, em_d);
        chk(aux_pd ? "R6" : "R1", "aux_up", aux_up, ea_u);
        chk(aux_pd ? "R6" : "R3", "aux_dn", aux_dn, ea_d);
      end
      ref_in     = (t == BASE);
      main_fb_in = (t == BASE + dm);
      aux_fb_in  = (t == BASE + da);
    end
    // R4: error |d| in window iff below WIN
    gm = main_pd ? 0 : ((iabs(dm) < WIN) ? gm + 1 : 0);
    ga = aux_pd  ? 0 : ((iabs(da) < WIN) ? ga + 1 : 0);
    check_lock();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "main_up", main_up, 0);
    chk("R10", "main_dn", main_dn, 0);
    chk("R10", "aux_up", aux_up, 0);
    chk("R10", "aux_dn", aux_dn, 0);
    chk("R10", "lock_out", lock_out, 0);
    chk("R10", "lock_oe", lock_oe, 1);
    rst_n = 1'b1;

    // push-pull, main offset swept, aux at zero error
    for (int d = -5; d <= 5; d++)
      for (int k = 0; k < 5; k++) compare(d, 0);

    // open-drain, aux swept, main lagging by one
    lock_drive = 1'b1;
    for (int d = -5; d <= 5; d++)
      for (int k = 0; k < 5; k++) compare(1, d);

    // main powered down: aux alone decides (R6, R7)
    lock_drive = 1'b0;
    main_pd = 1'b1;
    for (int d = -5; d <= 5; d++)
      for (int k = 0; k < 5; k++) compare(3, d);

    // aux powered down, main relocks from scratch, pad mode alternates
    main_pd = 1'b0;
    aux_pd  = 1'b1;
    for (int d = -4; d <= 4; d++)
      for (int k = 0; k < 5; k++) begin
        lock_drive = d[0];
        compare(d, 0);
      end

    // both down: R8 in both pad modes
    main_pd = 1'b1;
    for (int k = 0; k < 4; k++) begin
      lock_drive = k[0];
      compare(0, 0);
    end

    // release both: R6 requires NQ fresh comparisons
    main_pd = 1'b0;
    aux_pd  = 1'b0;
    lock_drive = 1'b0;
    for (int k = 0; k < 6; k++) compare(-2, 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #3000000;
    bad++;
    total++;
    $display("FAIL all watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule